// File: doc/BRIEF.md
# Dual-Clock Width-Converting Block RAM

This block is a true two-port synchronous memory. It holds 16384 data bits and 2048 parity bits. Each port has its own clock and can run in a separate clock domain. Each port also has its own enable, write enable, address, write data, write parity, read data, read parity and a synchronous clear of its output register. Reads and writes both take effect on the rising edge of the port's own clock.

The data width of each port is fixed by its own parameter. The widths 1, 2 and 4 carry no parity. Width 8 carries one parity bit, and width 16 carries two. Both ports address the same storage, so one port can store narrow words that the other port reads back as wide words. This is how the block is used for width conversion between two datapaths, for example one producing bytes and one consuming halfwords. Parameters also give the initial contents of the data and parity arrays.

Top module: `dcbr_ram`

## Requirements
- R1: When a port's enable is high and its output clear is low, the data and parity outputs show, after that rising edge, the contents at the address presented at that edge.
- R2: When enable and write enable are both high at a rising edge, the write data and write parity are stored at the addressed location, and a later read returns them.
- R3: The data width parameter takes the values 1, 2, 4, 8 or 16. The address width is then 14, 13, 12, 11 or 10 bits, and the number of parity bits is 0, 0, 0, 1 or 2. A port with no parity still has a one-bit parity pin.
- R4: Storage is organised as 1024 rows of 16 bits. An address of a port of width W selects row address/(16/W) and bits starting at (address mod (16/W))*W. A lower narrow address therefore lands in less significant bits of the wide word.
- R5: Parity is stored as 1024 rows of 2 bits. An 8-bit port at address a uses parity bit a[0] of row a>>1. A 16-bit port uses both parity bits of its row, with bit 0 belonging to the low byte. Ports narrower than 8 ignore their parity input and read 0 on their parity output.
- R6: When a port's enable is low, that port neither writes nor reads, and its outputs hold their previous values.
- R7: During a write, the outputs of the writing port show the contents the location held before the write.
- R8: When enable and output clear are both high at a rising edge, the data and parity outputs become 0. A write requested in the same cycle is still performed.
- R9: Row r of the data array starts with the value INIT_DATA[16r+15:16r], and row r of the parity array starts with INIT_PAR[2r+1:2r].
- R10: Data written through one port is readable through the other port, which runs on its own clock, once the writing edge has passed.
- R11: Driving a port's active-low reset low clears that port's outputs at once. The port leaves reset on its own clock, and the memory contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable |
| ssr_a | input | 1 | Port A synchronous output clear |
| addr_a | input | addr_w(A_DW) | Port A address |
| din_a | input | A_DW | Port A write data |
| dip_a | input | par_w(A_DW) | Port A write parity |
| dout_a | output | A_DW | Port A read data |
| dop_a | output | par_w(A_DW) | Port A read parity |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable |
| ssr_b | input | 1 | Port B synchronous output clear |
| addr_b | input | addr_w(B_DW) | Port B address |
| din_b | input | B_DW | Port B write data |
| dip_b | input | par_w(B_DW) | Port B write parity |
| dout_b | output | B_DW | Port B read data |
| dop_b | output | par_w(B_DW) | Port B read parity |

## Verification
The hardest case to reach from the ports is a row whose bits were last written by two different ports. In that case the read must merge the halves correctly, one bit at a time. The stimulus sets this up in two steps. It first writes a row as a whole through the 16-bit port. It then overwrites single bytes through the 8-bit port, which runs on a clock of a different period. Both ports then read the row back, so each read depends on the per-bit choice of the newest copy. A second instance built with a 4-bit port checks the nibble lane order. It also checks that a parity bit driven on a port without parity leaves the parity array untouched.

// File: rtl/dcbr_pkg.sv
package dcbr_pkg;
  localparam int ROW_W     = 16;
  localparam int ROWS      = 1024;
  localparam int ROW_AW    = $clog2(ROWS);
  localparam int PAR_W     = ROW_W / 8;
  localparam int DATA_BITS = ROW_W * ROWS;
  localparam int PAR_BITS  = PAR_W * ROWS;
  localparam int SH_W      = $clog2(ROW_W);

  function automatic int lane_w(input int dw);
    return $clog2(ROW_W / dw);
  endfunction

  function automatic int addr_w(input int dw);
    return ROW_AW + lane_w(dw);
  endfunction

  function automatic int par_w(input int dw);
    return (dw >= 8) ? dw / 8 : 1;
  endfunction
endpackage

// File: rtl/dcbr_rst_sync.sv
module dcbr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic q1, q1_n;

  assign q1_n = 1'b1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q1     <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      q1     <= q1_n;
      srst_n <= q1;
    end
  end
endmodule

// File: rtl/dcbr_port_map.sv
module dcbr_port_map import dcbr_pkg::*; #(
  parameter int DW = 8
) (
  input  logic                    en,
  input  logic                    we,
  input  logic [addr_w(DW)-1:0]   addr,
  input  logic [DW-1:0]           din,
  input  logic [par_w(DW)-1:0]    dip,
  input  logic [ROW_W-1:0]        row_q,
  input  logic [PAR_W-1:0]        rpar_q,
  output logic [ROW_AW-1:0]       row,
  output logic                    wr,
  output logic [ROW_W-1:0]        wdata,
  output logic [ROW_W-1:0]        wmask,
  output logic [PAR_W-1:0]        wpar,
  output logic [PAR_W-1:0]        wpmask,
  output logic [DW-1:0]           word,
  output logic [par_w(DW)-1:0]    wordp
);
  localparam int AW     = addr_w(DW);
  localparam int LW     = lane_w(DW);
  localparam int LSEL_W = (LW > 0) ? LW : 1;

  logic [LSEL_W-1:0] lane;
  logic [SH_W-1:0]   sh;

  // Low address bits pick the lane inside a row (R4)
  generate
    if (LW > 0) begin : g_lanes
      assign lane = addr[LW-1:0];
    end else begin : g_full
      assign lane = '0;
    end
  endgenerate

  assign row = addr[AW-1:LW];
  assign wr  = en & we;
  assign sh  = SH_W'(lane) * SH_W'(DW);

  always_comb begin
    wdata = ROW_W'(din) << sh;
    wmask = ROW_W'({DW{1'b1}}) << sh;
    word  = DW'(row_q >> sh);
  end

  // Parity lane handling depends on the width variant (R5)
  generate
    if (DW == ROW_W) begin : g_par_full
      assign wpar   = dip;
      assign wpmask = '1;
      assign wordp  = rpar_q;
    end else if (DW == 8) begin : g_par_byte
      assign wpar   = PAR_W'(dip) << lane;
      assign wpmask = PAR_W'(1) << lane;
      assign wordp  = rpar_q[lane];
    end else begin : g_par_none
      logic unused_par;
      assign unused_par = ^{dip, rpar_q};
      assign wpar   = '0;
      assign wpmask = '0;
      assign wordp  = '0;
    end
  endgenerate
endmodule

// File: rtl/dcbr_store.sv
module dcbr_store import dcbr_pkg::*; #(
  parameter logic [DATA_BITS-1:0] INIT_DATA = '0,
  parameter logic [PAR_BITS-1:0]  INIT_PAR  = '0
) (
  input  logic              clk_a,
  input  logic              a_wr,
  input  logic [ROW_AW-1:0] a_row,
  input  logic [ROW_W-1:0]  a_wdata,
  input  logic [ROW_W-1:0]  a_wmask,
  input  logic [PAR_W-1:0]  a_wpar,
  input  logic [PAR_W-1:0]  a_wpmask,
  output logic [ROW_W-1:0]  a_rdata,
  output logic [PAR_W-1:0]  a_rpar,
  input  logic              clk_b,
  input  logic              b_wr,
  input  logic [ROW_AW-1:0] b_row,
  input  logic [ROW_W-1:0]  b_wdata,
  input  logic [ROW_W-1:0]  b_wmask,
  input  logic [PAR_W-1:0]  b_wpar,
  input  logic [PAR_W-1:0]  b_wpmask,
  output logic [ROW_W-1:0]  b_rdata,
  output logic [PAR_W-1:0]  b_rpar
);
  // One copy per writing port, plus per-bit tags telling which copy is newest
  logic [ROW_W-1:0] mem_a [ROWS];
  logic [ROW_W-1:0] mem_b [ROWS];
  logic [ROW_W-1:0] tag_a [ROWS];
  logic [ROW_W-1:0] tag_b [ROWS];
  logic [PAR_W-1:0] pmem_a [ROWS];
  logic [PAR_W-1:0] pmem_b [ROWS];
  logic [PAR_W-1:0] ptag_a [ROWS];
  logic [PAR_W-1:0] ptag_b [ROWS];

  logic [ROW_W-1:0] a_mem_n, a_tag_n, b_mem_n, b_tag_n;
  logic [PAR_W-1:0] a_pmem_n, a_ptag_n, b_pmem_n, b_ptag_n;
  logic [ROW_W-1:0] a_sel, b_sel;
  logic [PAR_W-1:0] a_psel, b_psel;

  // Initial contents come from parameters (R9)
  initial begin
    for (int r = 0; r < ROWS; r++) begin
      mem_a[r]  = INIT_DATA[r*ROW_W +: ROW_W];
      mem_b[r]  = INIT_DATA[r*ROW_W +: ROW_W];
      tag_a[r]  = '0;
      tag_b[r]  = '0;
      pmem_a[r] = INIT_PAR[r*PAR_W +: PAR_W];
      pmem_b[r] = INIT_PAR[r*PAR_W +: PAR_W];
      ptag_a[r] = '0;
      ptag_b[r] = '0;
    end
  end

  // Port A marks its bits newest by making its tag equal the other tag
  always_comb begin
    a_mem_n  = (mem_a[a_row] & ~a_wmask) | (a_wdata & a_wmask);
    a_tag_n  = (tag_a[a_row] & ~a_wmask) | (tag_b[a_row] & a_wmask);
    a_pmem_n = (pmem_a[a_row] & ~a_wpmask) | (a_wpar & a_wpmask);
    a_ptag_n = (ptag_a[a_row] & ~a_wpmask) | (ptag_b[a_row] & a_wpmask);
  end

  // Port B marks its bits newest by making its tag differ from the other tag
  always_comb begin
    b_mem_n  = (mem_b[b_row] & ~b_wmask) | (b_wdata & b_wmask);
    b_tag_n  = (tag_b[b_row] & ~b_wmask) | (~tag_a[b_row] & b_wmask);
    b_pmem_n = (pmem_b[b_row] & ~b_wpmask) | (b_wpar & b_wpmask);
    b_ptag_n = (ptag_b[b_row] & ~b_wpmask) | (~ptag_a[b_row] & b_wpmask);
  end

  always_ff @(posedge clk_a) begin
    if (a_wr) begin
      mem_a[a_row]  <= a_mem_n;
      tag_a[a_row]  <= a_tag_n;
      pmem_a[a_row] <= a_pmem_n;
      ptag_a[a_row] <= a_ptag_n;
    end
  end

  always_ff @(posedge clk_b) begin
    if (b_wr) begin
      mem_b[b_row]  <= b_mem_n;
      tag_b[b_row]  <= b_tag_n;
      pmem_b[b_row] <= b_pmem_n;
      ptag_b[b_row] <= b_ptag_n;
    end
  end

  // Read merge: each bit comes from whichever copy holds its newest value
  always_comb begin
    a_sel   = tag_a[a_row] ^ tag_b[a_row];
    a_psel  = ptag_a[a_row] ^ ptag_b[a_row];
    a_rdata = (mem_a[a_row] & ~a_sel) | (mem_b[a_row] & a_sel);
    a_rpar  = (pmem_a[a_row] & ~a_psel) | (pmem_b[a_row] & a_psel);
    b_sel   = tag_a[b_row] ^ tag_b[b_row];
    b_psel  = ptag_a[b_row] ^ ptag_b[b_row];
    b_rdata = (mem_a[b_row] & ~b_sel) | (mem_b[b_row] & b_sel);
    b_rpar  = (pmem_a[b_row] & ~b_psel) | (pmem_b[b_row] & b_psel);
  end
endmodule

// File: rtl/dcbr_out_reg.sv
module dcbr_out_reg #(
  parameter int DW = 8,
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          en,
  input  logic          ssr,
  input  logic [DW-1:0] word,
  input  logic [PW-1:0] wordp,
  output logic [DW-1:0] dout,
  output logic [PW-1:0] dop
);
  logic [DW-1:0] dout_n;
  logic [PW-1:0] dop_n;

  always_comb begin
    dout_n = dout;
    dop_n  = dop;
    if (en) begin
      if (ssr) begin
        dout_n = '0;
        dop_n  = '0;
      end else begin
        dout_n = word;
        dop_n  = wordp;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dout <= '0;
      dop  <= '0;
    end else begin
      dout <= dout_n;
      dop  <= dop_n;
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (en && !ssr) |=> (dout == $past(word)) && (dop == $past(wordp)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !en |=> $stable(dout) && $stable(dop));

  p_out_clear_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (en && ssr) |=> (dout == '0) && (dop == '0));

  p_reset_zero_r11: assert property (@(posedge clk)
    !srst_n |-> (dout == '0) && (dop == '0));
endmodule

// File: rtl/dcbr_ram.sv
module dcbr_ram import dcbr_pkg::*; #(
  parameter int                   A_DW      = 8,
  parameter int                   B_DW      = 16,
  parameter logic [DATA_BITS-1:0] INIT_DATA = '0,
  parameter logic [PAR_BITS-1:0]  INIT_PAR  = '0
) (
  input  logic                     clk_a,
  input  logic                     rst_a_n,
  input  logic                     en_a,
  input  logic                     we_a,
  input  logic                     ssr_a,
  input  logic [addr_w(A_DW)-1:0]  addr_a,
  input  logic [A_DW-1:0]          din_a,
  input  logic [par_w(A_DW)-1:0]   dip_a,
  output logic [A_DW-1:0]          dout_a,
  output logic [par_w(A_DW)-1:0]   dop_a,
  input  logic                     clk_b,
  input  logic                     rst_b_n,
  input  logic                     en_b,
  input  logic                     we_b,
  input  logic                     ssr_b,
  input  logic [addr_w(B_DW)-1:0]  addr_b,
  input  logic [B_DW-1:0]          din_b,
  input  logic [par_w(B_DW)-1:0]   dip_b,
  output logic [B_DW-1:0]          dout_b,
  output logic [par_w(B_DW)-1:0]   dop_b
);
  localparam int A_PW = par_w(A_DW);
  localparam int B_PW = par_w(B_DW);

  logic              srst_a_n, srst_b_n;
  logic [ROW_AW-1:0] a_row, b_row;
  logic              a_wr, b_wr;
  logic [ROW_W-1:0]  a_wdata, a_wmask, b_wdata, b_wmask, a_rdata, b_rdata;
  logic [PAR_W-1:0]  a_wpar, a_wpmask, b_wpar, b_wpmask, a_rpar, b_rpar;
  logic [A_DW-1:0]   a_word;
  logic [A_PW-1:0]   a_wordp;
  logic [B_DW-1:0]   b_word;
  logic [B_PW-1:0]   b_wordp;

  dcbr_rst_sync i_rst_a (.clk(clk_a), .arst_n(rst_a_n), .srst_n(srst_a_n));
  dcbr_rst_sync i_rst_b (.clk(clk_b), .arst_n(rst_b_n), .srst_n(srst_b_n));

  dcbr_port_map #(.DW(A_DW)) i_map_a (
    .en(en_a), .we(we_a), .addr(addr_a), .din(din_a), .dip(dip_a),
    .row_q(a_rdata), .rpar_q(a_rpar), .row(a_row), .wr(a_wr),
    .wdata(a_wdata), .wmask(a_wmask), .wpar(a_wpar), .wpmask(a_wpmask),
    .word(a_word), .wordp(a_wordp));

  dcbr_port_map #(.DW(B_DW)) i_map_b (
    .en(en_b), .we(we_b), .addr(addr_b), .din(din_b), .dip(dip_b),
    .row_q(b_rdata), .rpar_q(b_rpar), .row(b_row), .wr(b_wr),
    .wdata(b_wdata), .wmask(b_wmask), .wpar(b_wpar), .wpmask(b_wpmask),
    .word(b_word), .wordp(b_wordp));

  dcbr_store #(.INIT_DATA(INIT_DATA), .INIT_PAR(INIT_PAR)) i_store (
    .clk_a(clk_a), .a_wr(a_wr), .a_row(a_row), .a_wdata(a_wdata),
    .a_wmask(a_wmask), .a_wpar(a_wpar), .a_wpmask(a_wpmask),
    .a_rdata(a_rdata), .a_rpar(a_rpar),
    .clk_b(clk_b), .b_wr(b_wr), .b_row(b_row), .b_wdata(b_wdata),
    .b_wmask(b_wmask), .b_wpar(b_wpar), .b_wpmask(b_wpmask),
    .b_rdata(b_rdata), .b_rpar(b_rpar));

  dcbr_out_reg #(.DW(A_DW), .PW(A_PW)) i_out_a (
    .clk(clk_a), .srst_n(srst_a_n), .en(en_a), .ssr(ssr_a),
    .word(a_word), .wordp(a_wordp), .dout(dout_a), .dop(dop_a));

  dcbr_out_reg #(.DW(B_DW), .PW(B_PW)) i_out_b (
    .clk(clk_b), .srst_n(srst_b_n), .en(en_b), .ssr(ssr_b),
    .word(b_word), .wordp(b_wordp), .dout(dout_b), .dop(dop_b));
endmodule

// File: tb/test_dcbr_ram.sv
module test_dcbr_ram;
  function automatic logic [16383:0] mk_init();
    logic [16383:0] v;
    for (int w = 0; w < 1024; w++) v[w*16 +: 16] = 16'(w * 40503) ^ 16'h5A5A;
    return v;
  endfunction

  function automatic logic [2047:0] mk_pinit();
    logic [2047:0] v;
    for (int r = 0; r < 1024; r++) v[r*2 +: 2] = 2'(r) ^ 2'b10;
    return v;
  endfunction

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n, rst_b_n;
  always #10 clk_a = ~clk_a;
  always #18 clk_b = ~clk_b;

  logic ea, wa, sa, eb, wb, sb;
  logic [10:0] aa; logic [7:0] da; logic [0:0] pa; logic [7:0] qa; logic [0:0] qpa;
  logic [9:0] ab;  logic [15:0] db; logic [1:0] pb; logic [15:0] qb; logic [1:0] qpb;
  logic e2a, w2a, e2b, w2b;
  logic [11:0] a2a; logic [3:0] d2a; logic [0:0] p2a; logic [3:0] q2a; logic [0:0] qp2a;
  logic [9:0] a2b; logic [15:0] q2b; logic [1:0] qp2b;

  dcbr_ram #(.A_DW(8), .B_DW(16), .INIT_DATA(mk_init()), .INIT_PAR(mk_pinit())) i_dcbr_ram (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(ea), .we_a(wa), .ssr_a(sa), .addr_a(aa),
    .din_a(da), .dip_a(pa), .dout_a(qa), .dop_a(qpa),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(eb), .we_b(wb), .ssr_b(sb), .addr_b(ab),
    .din_b(db), .dip_b(pb), .dout_b(qb), .dop_b(qpb));

  dcbr_ram #(.A_DW(4), .B_DW(16)) i_dcbr_ram_n (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(e2a), .we_a(w2a), .ssr_a(1'b0), .addr_a(a2a),
    .din_a(d2a), .dip_a(p2a), .dout_a(q2a), .dop_a(qp2a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(e2b), .we_b(w2b), .ssr_b(1'b0), .addr_b(a2b),
    .din_b(16'h0), .dip_b(2'b00), .dout_b(q2b), .dop_b(qp2b));

  logic [15:0] md [1024];
  logic [1:0]  mp [1024];
  logic [15:0] nmd [1024];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [10:0] ad);
    return md[ad[10:1]][8*ad[0] +: 8];
  endfunction

  function automatic logic mpbit(input logic [10:0] ad);
    return mp[ad[10:1]][ad[0]];
  endfunction

  task automatic a_cyc(input logic e, input logic w, input logic s,
                       input logic [10:0] ad, input logic [7:0] d, input logic p);
    @(negedge clk_a);
    ea = e; wa = w; sa = s; aa = ad; da = d; pa = p;
    @(negedge clk_a);
    ea = 1'b0; wa = 1'b0; sa = 1'b0;
    if (e && w) begin
      md[ad[10:1]][8*ad[0] +: 8] = d;
      mp[ad[10:1]][ad[0]] = p;
    end
  endtask

  task automatic b_cyc(input logic e, input logic w, input logic s,
                       input logic [9:0] ad, input logic [15:0] d, input logic [1:0] p);
    @(negedge clk_b);
    eb = e; wb = w; sb = s; ab = ad; db = d; pb = p;
    @(negedge clk_b);
    eb = 1'b0; wb = 1'b0; sb = 1'b0;
    if (e && w) begin
      md[ad] = d;
      mp[ad] = p;
    end
  endtask

  task automatic a_read_chk(input string req, input logic [10:0] ad);
    a_cyc(1'b1, 1'b0, 1'b0, ad, 8'h00, 1'b0);
    chk(req, 32'(qa), 32'(mbyte(ad)));
    chk(req, 32'(qpa), 32'(mpbit(ad)));
  endtask

  task automatic b_read_chk(input string req, input logic [9:0] ad);
    b_cyc(1'b1, 1'b0, 1'b0, ad, 16'h0, 2'b00);
    chk(req, 32'(qb), 32'(md[ad]));
    chk(req, 32'(qpb), 32'(mp[ad]));
  endtask

  task automatic t_reset();
    #5;
    chk("R11 reset A data", 32'(qa), 32'h0);
    chk("R11 reset B data", 32'(qb), 32'h0);
    chk("R11 reset B parity", 32'(qpb), 32'h0);
    #100;
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    repeat (4) @(negedge clk_b);
  endtask

  task automatic t_init();
    for (int r = 0; r < 6; r++) b_read_chk("R9 R1 init via wide port", 10'(r));
    b_read_chk("R9 init last row", 10'd1023);
    a_read_chk("R4 R5 init byte lane 0", 11'd0);
    a_read_chk("R4 R5 init byte lane 1", 11'd1);
    a_read_chk("R4 R5 init byte", 11'd6);
    a_read_chk("R4 R5 init byte top", 11'd2047);
  endtask

  task automatic t_narrow_to_wide();
    for (int i = 0; i < 32; i++)
      a_cyc(1'b1, 1'b1, 1'b0, 11'(40 + i), 8'(i * 37 + 5), 1'(i ^ (i >> 2)));
    a_cyc(1'b1, 1'b1, 1'b0, 11'd2047, 8'hA7, 1'b1);
    for (int r = 20; r < 36; r++) b_read_chk("R2 R4 R5 R10 bytes seen as words", 10'(r));
    b_read_chk("R3 top address on both widths", 10'd1023);
  endtask

  task automatic t_read_before_write();
    logic [7:0] old8; logic old_p; logic [15:0] old16;
    old8 = mbyte(11'd40); old_p = mpbit(11'd40);
    a_cyc(1'b1, 1'b1, 1'b0, 11'd40, 8'h3C, ~old_p);
    chk("R7 old byte on write", 32'(qa), 32'(old8));
    chk("R7 old parity on write", 32'(qpa), 32'(old_p));
    old16 = md[50];
    b_cyc(1'b1, 1'b1, 1'b0, 10'd50, 16'h1234, 2'b01);
    chk("R7 old word on write", 32'(qb), 32'(old16));
    b_read_chk("R2 word write stored", 10'd50);
    a_read_chk("R2 byte write stored", 11'd40);
  endtask

  task automatic t_idle_hold();
    logic [7:0] seen;
    a_read_chk("R1 read before idle", 11'd41);
    seen = qa;
    a_cyc(1'b0, 1'b1, 1'b0, 11'd41, ~seen, 1'b1);
    chk("R6 output holds when disabled", 32'(qa), 32'(seen));
    a_read_chk("R6 disabled write ignored", 11'd41);
    b_cyc(1'b0, 1'b1, 1'b0, 10'd20, 16'hFFFF, 2'b11);
    b_read_chk("R6 disabled word write ignored", 10'd20);
  endtask

  task automatic t_clear();
    a_cyc(1'b1, 1'b1, 1'b1, 11'd42, 8'hC3, 1'b1);
    chk("R8 clear data", 32'(qa), 32'h0);
    chk("R8 clear parity", 32'(qpa), 32'h0);
    b_read_chk("R8 write during clear lands", 10'd21);
    b_cyc(1'b1, 1'b0, 1'b1, 10'd21, 16'h0, 2'b00);
    chk("R8 clear wide data", 32'(qb), 32'h0);
    chk("R8 clear wide parity", 32'(qpb), 32'h0);
  endtask

  task automatic t_wide_to_narrow();
    b_cyc(1'b1, 1'b1, 1'b0, 10'd60, 16'hBEEF, 2'b10);
    a_read_chk("R10 R4 low byte of word", 11'd120);
    a_read_chk("R10 R5 high byte and parity", 11'd121);
    a_cyc(1'b1, 1'b1, 1'b0, 11'd121, 8'h5D, 1'b0);
    b_read_chk("R10 merged row after byte overwrite", 10'd60);
    a_read_chk("R10 merged row low byte kept", 11'd120);
  endtask

  task automatic t_nibbles();
    for (int l = 0; l < 4; l++) begin
      @(negedge clk_a);
      e2a = 1'b1; w2a = 1'b1; a2a = 12'(28 + l); d2a = 4'(l + 1); p2a = 1'b1;
      @(negedge clk_a);
      e2a = 1'b0; w2a = 1'b0;
      nmd[7][4*l +: 4] = 4'(l + 1);
    end
    @(negedge clk_b);
    e2b = 1'b1; w2b = 1'b0; a2b = 10'd7;
    @(negedge clk_b);
    e2b = 1'b0;
    chk("R4 R3 nibble lane order", 32'(q2b), 32'(nmd[7]));
    chk("R5 parity ignored below byte width", 32'(qp2b), 32'h0);
    @(negedge clk_a);
    e2a = 1'b1; a2a = 12'd30;
    @(negedge clk_a);
    e2a = 1'b0;
    chk("R4 nibble readback", 32'(q2a), 32'h3);
    chk("R5 narrow parity output is 0", 32'(qp2a), 32'h0);
  endtask

  task automatic t_mid_reset();
    a_read_chk("R11 read before reset", 11'd121);
    @(negedge clk_a);
    rst_a_n = 1'b0;
    #2;
    chk("R11 async clear of A", 32'(qa), 32'h0);
    repeat (2) @(negedge clk_a);
    rst_a_n = 1'b1;
    repeat (3) @(negedge clk_a);
    a_read_chk("R11 contents kept through reset", 11'd121);
  endtask

  initial begin
    rst_a_n = 1'b0; rst_b_n = 1'b0;
    ea = 0; wa = 0; sa = 0; aa = '0; da = '0; pa = '0;
    eb = 0; wb = 0; sb = 0; ab = '0; db = '0; pb = '0;
    e2a = 0; w2a = 0; a2a = '0; d2a = '0; p2a = '0;
    e2b = 0; w2b = 0; a2b = '0;
    for (int r = 0; r < 1024; r++) begin
      md[r] = 16'(r * 40503) ^ 16'h5A5A;
      mp[r] = 2'(r) ^ 2'b10;
      nmd[r] = 16'h0;
    end
    t_reset();
    t_init();
    t_narrow_to_wide();
    t_read_before_write();
    t_idle_hold();
    t_clear();
    t_wide_to_narrow();
    t_nibbles();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule